// File: doc/BRIEF.md
# LIN Transmit Enable Guard

This block sits between the transmit-data input of a LIN transceiver and its bus driver. It passes a dominant request to the driver only in normal mode, and only while no inhibit cause is active. Three causes can force the bus recessive.

- **Stuck dominant:** the transmit input has been low for too many consecutive clock samples.
- **Over-temperature:** the junction-temperature flag is set, or has recently been set.
- **Low battery:** the battery-monitor comparators report an undervoltage condition.

Each cause recovers in its own way. A stuck-dominant release ends on the first high sample of the transmit input. A thermal lock ends only once the temperature flag is low and a recessive (high) transmit level is then sampled. A low-battery lock ends only when the upper monitor comparator reports the supply back above its high level.

Reception is never gated. The received bus level is forwarded in normal mode whatever the inhibit state. One sticky status bit per cause reports that cause until it has been re-armed. The stuck-dominant limit is the parameter `TIMEOUT_CYC`, in clock cycles.

Top module: `lin_tx_guard`

## Requirements
- R1: After reset all three status bits are 0, and the driver output is 0 while the transmit input is high (1 = recessive).
- R2: `drv_dom_o` is 1 only when `normal_i` is 1, `txd_i` is 0, and no inhibit cause is active.
- R3: On the `TIMEOUT_CYC`-th consecutive low sample of `txd_i` in normal mode, `st_timeout_o` becomes 1 and the driver is released. The earlier low samples leave it dominant.
- R4: The first high sample of `txd_i` clears `st_timeout_o` and restarts the low-sample count from zero.
- R5: While `hot_i` is 1 the driver is recessive. A sampled `hot_i` of 1 sets `st_thermal_o`.
- R6: `st_thermal_o`, and with it the inhibit, stays 1 after `hot_i` falls. It clears only at an edge where `hot_i` is 0 and `txd_i` is sampled high.
- R7: A sampled `bat_low_i` of 1 sets `st_uv_o`, and `bat_low_i` gates the driver at once. `st_uv_o` stays 1 until an edge where `bat_high_i` is 1 and `bat_low_i` is 0.
- R8: In normal mode `rxd_o` equals `bus_i` (0 = dominant) under every inhibit cause. Outside normal mode `rxd_o` is 1.
- R9: Outside normal mode the driver is recessive, the low-sample count is cleared and `st_timeout_o` is cleared. The thermal and battery locks keep tracking.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| txd_i | input | 1 | Transmit data, 0 = dominant |
| normal_i | input | 1 | 1 when the transceiver is in normal mode |
| hot_i | input | 1 | Over-temperature flag from the hysteretic sensor |
| bat_low_i | input | 1 | Supply below the monitor low level |
| bat_high_i | input | 1 | Supply above the monitor high level |
| bus_i | input | 1 | Received bus level, 0 = dominant |
| drv_dom_o | output | 1 | 1 drives the bus dominant |
| rxd_o | output | 1 | Received data, 0 = dominant |
| st_timeout_o | output | 1 | Stuck-dominant release active |
| st_thermal_o | output | 1 | Thermal lock active |
| st_uv_o | output | 1 | Undervoltage lock active |

## Verification
Two events can land on the same clock edge.

- **Expiry and over-temperature together:** the stuck-dominant expiry and the onset of over-temperature can coincide. The bench raises `hot_i` on exactly the `TIMEOUT_CYC`-th low sample of `txd_i`. It expects both status bits to rise together and the driver to stay recessive.
- **Shared recovery edge:** the following edge returns `txd_i` high with `hot_i` low. This single sample must clear both locks at once.

A scoreboard compares each expected output set one nanosecond after the edge it belongs to.

// File: rtl/lin_tx_guard.sv
module lin_tx_guard #(
  parameter int TIMEOUT_CYC = 12500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic txd_i,
  input  logic normal_i,
  input  logic hot_i,
  input  logic bat_low_i,
  input  logic bat_high_i,
  input  logic bus_i,
  output logic drv_dom_o,
  output logic rxd_o,
  output logic st_timeout_o,
  output logic st_thermal_o,
  output logic st_uv_o
);
  localparam int CW = $clog2(TIMEOUT_CYC + 1);
  localparam logic [CW-1:0] LIMIT = CW'(TIMEOUT_CYC);
  localparam logic [CW-1:0] LAST  = CW'(TIMEOUT_CYC - 1);

  logic [CW-1:0] low_cnt;
  logic          tmo_q, therm_q, uv_q;
  logic          low_now, inhibit;

  assign low_now = normal_i & ~txd_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_cnt <= '0;
      tmo_q   <= 1'b0;
    end else begin
      if (!low_now) low_cnt <= '0;
      else if (low_cnt != LIMIT) low_cnt <= low_cnt + 1'b1;
      tmo_q <= low_now & (tmo_q | (low_cnt == LAST));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) therm_q <= 1'b0;
    else if (hot_i) therm_q <= 1'b1;
    else if (txd_i) therm_q <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) uv_q <= 1'b0;
    else if (bat_low_i) uv_q <= 1'b1;
    else if (bat_high_i) uv_q <= 1'b0;
  end

  assign inhibit      = tmo_q | hot_i | therm_q | bat_low_i | uv_q;
  assign drv_dom_o    = low_now & ~inhibit;
  assign rxd_o        = normal_i ? bus_i : 1'b1;
  assign st_timeout_o = tmo_q;
  assign st_thermal_o = therm_q;
  assign st_uv_o      = uv_q;

  p_tmo_needs_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_timeout_o) |-> $past(!txd_i && normal_i));
  p_tmo_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    txd_i |=> !st_timeout_o);
  p_hot_sets_r5: assert property (@(posedge clk) disable iff (!rst_n)
    hot_i |=> st_thermal_o);
  p_hot_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    hot_i |-> !drv_dom_o);
  p_therm_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st_thermal_o && !txd_i) |=> st_thermal_o);
  p_uv_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st_uv_o && !bat_high_i) |=> st_uv_o);
  p_mode_exit_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !normal_i |=> !st_timeout_o);
endmodule

// File: tb/lin_tx_guard_tb_top.sv
module lin_tx_guard_tb_top;
  localparam int T = 8;
  logic clk = 1'b0, rst_n = 1'b0;
  logic txd = 1'b1, nrm = 1'b0, hot = 1'b0, blo = 1'b0, bhi = 1'b0, bus = 1'b1;
  logic drv, rxd, stt, sth, stu;
  int total = 0, fails = 0;
  bit done = 1'b0;

  typedef struct {logic drv, tmo, th, uv, rxd; string tag;} exp_t;
  exp_t q[$];

  always #2 clk = ~clk;

  lin_tx_guard #(.TIMEOUT_CYC(T)) dut_i (
    .clk(clk), .rst_n(rst_n), .txd_i(txd), .normal_i(nrm), .hot_i(hot),
    .bat_low_i(blo), .bat_high_i(bhi), .bus_i(bus), .drv_dom_o(drv),
    .rxd_o(rxd), .st_timeout_o(stt), .st_thermal_o(sth), .st_uv_o(stu));

  task automatic step(input logic t, n, h, bl, bh, b,
                      input logic ed, et, eh, eu, er, input string tag);
    @(negedge clk);
    txd = t; nrm = n; hot = h; blo = bl; bhi = bh; bus = b;
    q.push_back('{ed, et, eh, eu, er, tag});
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", total - fails, total);
    $finish;
  endtask

  initial begin
    exp_t e;
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        e = q.pop_front();
        total++;
        if ({drv, stt, sth, stu, rxd} !== {e.drv, e.tmo, e.th, e.uv, e.rxd}) begin
          fails++;
          $display("FAIL %s: drv/tmo/th/uv/rxd actual %b%b%b%b%b expected %b%b%b%b%b",
                   e.tag, drv, stt, sth, stu, rxd, e.drv, e.tmo, e.th, e.uv, e.rxd);
        end
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog: actual hung expected finished");
      summary();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    step(1,0,0,0,0,1, 0,0,0,0,1, "R1");
    step(1,1,0,0,0,1, 0,0,0,0,1, "R1");
    // R2 / R3: dominant for T-1 samples, released on the T-th
    for (int i = 1; i < T; i++) step(0,1,0,0,0,0, 1,0,0,0,0, "R2");
    step(0,1,0,0,0,0, 0,1,0,0,0, "R3");
    step(0,1,0,0,0,0, 0,1,0,0,0, "R3");
    // R4 recovery and restart
    step(1,1,0,0,0,1, 0,0,0,0,1, "R4");
    step(0,1,0,0,0,0, 1,0,0,0,0, "R4");
    step(1,1,0,0,0,1, 0,0,0,0,1, "R4");
    // R5 / R6 thermal lock
    step(0,1,1,0,0,0, 0,0,1,0,0, "R5");
    step(0,1,0,0,0,0, 0,0,1,0,0, "R6");
    step(1,1,0,0,0,1, 0,0,0,0,1, "R6");
    step(0,1,0,0,0,0, 1,0,0,0,0, "R6");
    step(1,1,0,0,0,1, 0,0,0,0,1, "R6");
    // R7 / R8 undervoltage with reception running
    step(0,1,0,1,0,0, 0,0,0,1,0, "R7");
    step(0,1,0,0,0,0, 0,0,0,1,0, "R8");
    step(0,1,0,0,0,1, 0,0,0,1,1, "R8");
    step(0,1,0,0,1,0, 1,0,0,0,0, "R7");
    step(1,1,0,0,0,1, 0,0,0,0,1, "R7");
    // R9 mode exit clears the count
    for (int i = 1; i < T; i++) step(0,1,0,0,0,0, 1,0,0,0,0, "R9");
    step(0,0,0,0,0,0, 0,0,0,0,1, "R9");
    for (int i = 1; i < T; i++) step(0,1,0,0,0,0, 1,0,0,0,0, "R9");
    step(1,1,0,0,0,1, 0,0,0,0,1, "R9");
    // R3 with R5 on the same edge, then a shared recovery (R4, R6)
    for (int i = 1; i < T; i++) step(0,1,0,0,0,0, 1,0,0,0,0, "R3");
    step(0,1,1,0,0,0, 0,1,1,0,0, "R3");
    step(1,1,0,0,0,1, 0,0,0,0,1, "R6");
    step(0,1,0,0,0,0, 1,0,0,0,0, "R4");
    @(posedge clk); #2;
    done = 1'b1;
    summary();
  end
endmodule